// File: doc/BRIEF.md
# Dual-Mode Pixel Frame Serializer

This block turns one parallel video pixel (24 bits of colour plus vertical sync, horizontal sync and data enable) into a 30-bit frame and shifts that frame out serially on a bit-rate clock. Each frame holds the 27 payload bits, two reserved bits that are always 0, and an even-parity bit. A lane-mode input selects either one serial lane carrying all 30 bits per pixel period or two lanes carrying 15 bits each. A forwarded clock at the pixel rate goes out beside the data, and a transmit-enable input shuts the block down so that all outputs are released.

Everything runs on the bit clock, which is supplied from outside at 30 or 15 times the pixel rate. The pixel source keeps its word stable and uses the forwarded clock (or its own copy of the pixel clock) to pace itself. The block samples the pixel word at each frame boundary, and that word is shifted out during the following frame, so frames follow one another with no gap. A change of lane mode or of transmit enable acts only at a frame boundary.

Each output pin has a separate output-enable signal. The pad ring that drives the physical pins turns each enable into a high-impedance state.

Top module: `pixel_frame_serializer`

## Requirements
- R1: The last bit of every frame is an even-parity bit over the 27 payload bits of the same pixel. The total count of ones among the 27 payload bits and the parity bit is even.
- R2: With `twoLaneSel` low, lane 0 sends 30 bits per frame, one per bit clock, in this order: blue 7, blue 6, red 7 down to red 0, green 7 down to green 0, blue 5 down to blue 0, vertical sync, horizontal sync, data enable, 0, 0, parity. Lane 1 has its enable low and its data low.
- R3: With `twoLaneSel` high, each frame lasts 15 bit clocks. Lane 0 sends red 7 down to red 0, green 7 down to green 4, vertical sync, 0, parity.
- R4: With `twoLaneSel` high, lane 1 sends, in the same 15 bit clocks, blue 7, blue 6, green 3 down to green 0, blue 5 down to blue 0, horizontal sync, data enable, 0.
- R5: While the block is shut down, `lane0Oe`, `lane1Oe` and `clkOe` are low and `lane0Data`, `lane1Data` and `clkOut` are low. `clkOe` always equals `lane0Oe`, and `lane1Oe` is high only when `lane0Oe` is high.
- R6: `clkOut` goes high on the first bit of each frame. It stays high for 15 of the 30 bits in one-lane mode and for 8 of the 15 bits in two-lane mode, and is low for the rest of the frame.
- R7: The pixel inputs are sampled on the clock edge that starts a frame, and that pixel is sent in the next frame. Frames follow back to back with no idle bits.
- R8: A change of `twoLaneSel` takes effect only on the first bit of a frame. A frame that has started keeps its mode to its end.
- R9: Lowering `txEn` takes effect only after the last bit of the current frame. Raising `txEn` while shut down starts a new frame at bit 0 on the next clock edge.
- R10: While `rstN` is low, all enables and all outputs are low.
- R11: The reserved bits are always 0: bits 27 and 28 of the one-lane frame, bit 13 of lane 0 and bit 14 of lane 1 in two-lane mode. This holds even when every payload bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Bit-rate clock, 30 or 15 times the pixel rate |
| rstN | input | 1 | Active-low synchronous reset |
| txEn | input | 1 | Transmit enable; low shuts the block down at a frame boundary |
| twoLaneSel | input | 1 | Lane mode: 0 selects one lane of 30 bits, 1 selects two lanes of 15 bits |
| pixRed | input | 8 | Red component |
| pixGreen | input | 8 | Green component |
| pixBlue | input | 8 | Blue component |
| pixVsync | input | 1 | Vertical sync |
| pixHsync | input | 1 | Horizontal sync |
| pixDe | input | 1 | Data enable |
| lane0Data | output | 1 | Serial data, lane 0 |
| lane0Oe | output | 1 | Output enable, lane 0 |
| lane1Data | output | 1 | Serial data, lane 1 |
| lane1Oe | output | 1 | Output enable, lane 1 |
| clkOut | output | 1 | Forwarded clock at the pixel rate |
| clkOe | output | 1 | Output enable for the forwarded clock |

## Verification
The bound checker checks the output-enable relations and the quiet outputs of shutdown on every cycle, along with the period and high time of the forwarded clock. It also checks that a lane-mode change or an enable edge lines up with a frame start or frame end. The per-bit placement of colour, sync and reserved bits in both lane layouts, the parity value and the one-frame delay from pixel sample to transmission depend on the data. Only the bench shows them, by comparing every output bit against its own frame model while it runs pixel patterns, mode switches in mid-frame, and shutdown and restart.

// File: rtl/pixser_pkg.sv
package pixser_pkg;

  localparam int COLOR_W = 8;
  localparam int SYNC_W  = 3;
  localparam int RSV_W   = 2;
  localparam int PAY_W   = 3 * COLOR_W + SYNC_W;
  localparam int FRAME_W = PAY_W + RSV_W + 1;
  localparam int LANES   = 2;
  localparam int LANE_W  = FRAME_W / LANES;
  localparam int CNT_W   = $clog2(FRAME_W);

  // Positions inside the one-lane sequence (bit 0 leaves first)
  localparam int POS_BHI  = 0;
  localparam int POS_RED  = 2;
  localparam int POS_GRN  = POS_RED + COLOR_W;
  localparam int POS_BLO  = POS_GRN + COLOR_W;
  localparam int POS_VS   = POS_BLO + COLOR_W - 2;
  localparam int POS_HS   = POS_VS + 1;
  localparam int POS_DE   = POS_VS + 2;
  localparam int POS_RSV0 = POS_VS + 3;
  localparam int POS_RSV1 = POS_VS + 4;
  localparam int POS_PAR  = FRAME_W - 1;

  typedef struct packed {
    logic [COLOR_W-1:0] red;
    logic [COLOR_W-1:0] green;
    logic [COLOR_W-1:0] blue;
    logic               vsync;
    logic               hsync;
    logic               de;
  } pixel_t;

  typedef struct packed {
    logic load;         // frame boundary: capture pixel, reload shifters
    logic shift;        // advance shifters by one bit
    logic active;       // transmitting
    logic twoLane;      // mode of the frame now on the wire
    logic nextTwoLane;  // mode of the frame being loaded
    logic clkHigh;      // forwarded clock level
  } serStrobe_t;

  // Frame in one-lane order: element i is the i-th bit sent.
  function automatic logic [FRAME_W-1:0] buildFrame(input pixel_t p);
    logic [FRAME_W-1:0] f;
    f = '0;
    f[POS_BHI]     = p.blue[COLOR_W-1];
    f[POS_BHI + 1] = p.blue[COLOR_W-2];
    for (int k = 0; k < COLOR_W; k++) begin
      f[POS_RED + k] = p.red[COLOR_W-1-k];
      f[POS_GRN + k] = p.green[COLOR_W-1-k];
    end
    for (int k = 0; k < COLOR_W - 2; k++) begin
      f[POS_BLO + k] = p.blue[COLOR_W-3-k];
    end
    f[POS_VS]   = p.vsync;
    f[POS_HS]   = p.hsync;
    f[POS_DE]   = p.de;
    f[POS_RSV0] = 1'b0;
    f[POS_RSV1] = 1'b0;
    f[POS_PAR]  = ^{p.red, p.green, p.blue, p.vsync, p.hsync, p.de};
    return f;
  endfunction

  // Which one-lane frame position feeds bit j of a lane in two-lane mode.
  function automatic int laneSrc(input int lane, input int j);
    int half;
    half = COLOR_W / 2;
    if (lane == 0) begin
      if (j < COLOR_W)              return POS_RED + j;
      else if (j < COLOR_W + half)  return POS_GRN + (j - COLOR_W);
      else if (j == COLOR_W + half) return POS_VS;
      else if (j == COLOR_W + half + 1) return POS_RSV0;
      else                          return POS_PAR;
    end else begin
      if (j < 2)                    return POS_BHI + j;
      else if (j < 2 + half)        return POS_GRN + half + (j - 2);
      else if (j < 2 + half + COLOR_W - 2) return POS_BLO + (j - 2 - half);
      else if (j == LANE_W - 3)     return POS_HS;
      else if (j == LANE_W - 2)     return POS_DE;
      else                          return POS_RSV1;
    end
  endfunction

endpackage

// File: rtl/pixser_ctrl.sv
module pixser_ctrl
  import pixser_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEn,
  input  logic       twoLaneSel,
  output serStrobe_t strobe
);

  localparam logic [CNT_W-1:0] LAST_ONE  = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] LAST_TWO  = CNT_W'(LANE_W - 1);
  localparam logic [CNT_W-1:0] HIGH_ONE  = CNT_W'(FRAME_W / 2);
  localparam logic [CNT_W-1:0] HIGH_TWO  = CNT_W'((LANE_W + 1) / 2);

  logic             active;
  logic             twoLane;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] lastIdx;
  logic             boundary;

  always_comb begin
    lastIdx  = twoLane ? LAST_TWO : LAST_ONE;
    boundary = !active || (bitCnt == lastIdx);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      twoLane <= 1'b0;
      bitCnt  <= '0;
    end else if (boundary) begin
      active  <= txEn;
      twoLane <= twoLaneSel;
      bitCnt  <= '0;
    end else begin
      bitCnt  <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.load        = boundary;
    strobe.shift       = active && !boundary;
    strobe.active      = active;
    strobe.twoLane     = twoLane;
    strobe.nextTwoLane = twoLaneSel;
    strobe.clkHigh     = active && (bitCnt < (twoLane ? HIGH_TWO : HIGH_ONE));
  end

endmodule

// File: rtl/pixser_datapath.sv
module pixser_datapath
  import pixser_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  serStrobe_t        strobe,
  input  pixel_t            pix,
  output logic [LANES-1:0]  laneData,
  output logic [LANES-1:0]  laneOe,
  output logic              clkOut,
  output logic              clkOe
);

  logic [FRAME_W-1:0] holdFrame;
  logic [FRAME_W-1:0] loadOne [LANES];
  logic [FRAME_W-1:0] loadTwo [LANES];
  logic [FRAME_W-1:0] laneReg [LANES];

  always_ff @(posedge clk) begin
    if (!rstN)            holdFrame <= '0;
    else if (strobe.load) holdFrame <= buildFrame(pix);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    // one-lane layout: lane 0 carries the whole frame, others idle
    for (genvar j = 0; j < FRAME_W; j++) begin : g_one
      if (l == 0) begin : g_carry
        assign loadOne[l][FRAME_W-1-j] = holdFrame[j];
      end else begin : g_idle
        assign loadOne[l][FRAME_W-1-j] = 1'b0;
      end
    end

    // two-lane layout: first LANE_W slots hold the mapped bits
    for (genvar j = 0; j < FRAME_W; j++) begin : g_two
      if (j < LANE_W) begin : g_map
        assign loadTwo[l][FRAME_W-1-j] = holdFrame[laneSrc(l, j)];
      end else begin : g_pad
        assign loadTwo[l][FRAME_W-1-j] = 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)             laneReg[l] <= '0;
      else if (strobe.load)  laneReg[l] <= strobe.nextTwoLane ? loadTwo[l] : loadOne[l];
      else if (strobe.shift) laneReg[l] <= {laneReg[l][FRAME_W-2:0], 1'b0};
    end

    if (l == 0) begin : g_oe0
      assign laneOe[l] = strobe.active;
    end else begin : g_oeN
      assign laneOe[l] = strobe.active && strobe.twoLane;
    end

    assign laneData[l] = laneReg[l][FRAME_W-1] && laneOe[l];
  end

  assign clkOut = strobe.clkHigh;
  assign clkOe  = strobe.active;

endmodule

// File: rtl/pixel_frame_serializer.sv
module pixel_frame_serializer
  import pixser_pkg::*;
(
  input  logic               bitClk,
  input  logic               rstN,
  input  logic               txEn,
  input  logic               twoLaneSel,
  input  logic [COLOR_W-1:0] pixRed,
  input  logic [COLOR_W-1:0] pixGreen,
  input  logic [COLOR_W-1:0] pixBlue,
  input  logic               pixVsync,
  input  logic               pixHsync,
  input  logic               pixDe,
  output logic               lane0Data,
  output logic               lane0Oe,
  output logic               lane1Data,
  output logic               lane1Oe,
  output logic               clkOut,
  output logic               clkOe
);

  serStrobe_t       strobe;
  pixel_t           pix;
  logic [LANES-1:0] laneData;
  logic [LANES-1:0] laneOe;

  assign pix = '{red: pixRed, green: pixGreen, blue: pixBlue,
                 vsync: pixVsync, hsync: pixHsync, de: pixDe};

  pixser_ctrl u_ctrl (
    .clk        (bitClk),
    .rstN       (rstN),
    .txEn       (txEn),
    .twoLaneSel (twoLaneSel),
    .strobe     (strobe)
  );

  pixser_datapath u_dp (
    .clk      (bitClk),
    .rstN     (rstN),
    .strobe   (strobe),
    .pix      (pix),
    .laneData (laneData),
    .laneOe   (laneOe),
    .clkOut   (clkOut),
    .clkOe    (clkOe)
  );

  assign lane0Data = laneData[0];
  assign lane1Data = laneData[1];
  assign lane0Oe   = laneOe[0];
  assign lane1Oe   = laneOe[1];

endmodule

// File: rtl/pixser_checker.sv
module pixser_checker (
  input logic clk,
  input logic rstN,
  input logic lane0Data,
  input logic lane0Oe,
  input logic lane1Data,
  input logic lane1Oe,
  input logic clkOut,
  input logic clkOe
);

  logic       prevClk;
  logic       haveRise;
  logic [7:0] sinceRise;
  logic       riseNow;
  logic       fallNow;

  assign riseNow = clkOut && !prevClk;
  assign fallNow = !clkOut && prevClk && clkOe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevClk   <= 1'b0;
      haveRise  <= 1'b0;
      sinceRise <= '0;
    end else begin
      prevClk <= clkOut;
      if (!clkOe)       haveRise <= 1'b0;
      else if (riseNow) haveRise <= 1'b1;
      if (riseNow)                 sinceRise <= '0;
      else if (sinceRise != 8'hFF) sinceRise <= sinceRise + 8'd1;
    end
  end

  // R5: lane 1 only drives alongside lane 0
  a_r5_lane1_needs_lane0: assert property (@(posedge clk) disable iff (!rstN)
    lane1Oe |-> lane0Oe);

  // R5: clock lane enabled together with lane 0
  a_r5_clk_with_lane0: assert property (@(posedge clk) disable iff (!rstN)
    clkOe == lane0Oe);

  // R5: released outputs are held low
  a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !lane0Oe |-> (!lane0Data && !lane1Data && !clkOut));

  // R2: lane 1 data low when it is not driven
  a_r2_lane1_low_off: assert property (@(posedge clk) disable iff (!rstN)
    !lane1Oe |-> !lane1Data);

  // R6: frame period is 15 or 30 bit clocks
  a_r6_clk_period: assert property (@(posedge clk) disable iff (!rstN)
    (riseNow && haveRise) |-> (sinceRise == 8'd14 || sinceRise == 8'd29));

  // R6: high time is 8 or 15 bit clocks
  a_r6_clk_high: assert property (@(posedge clk) disable iff (!rstN)
    (fallNow && haveRise) |-> (sinceRise == 8'd7 || sinceRise == 8'd14));

  // R8: a lane-mode change shows up only at a frame start
  a_r8_mode_at_frame: assert property (@(posedge clk) disable iff (!rstN)
    (lane0Oe && $past(lane0Oe) && (lane1Oe != $past(lane1Oe))) |-> riseNow);

  // R9: enabling starts on bit 0 of a frame
  a_r9_start_bit0: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lane0Oe) |-> clkOut);

  // R9: shutdown only follows a frame's last bit (clock low there)
  a_r9_stop_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lane0Oe) |-> !$past(clkOut));

endmodule

bind pixel_frame_serializer pixser_checker u_chk (
  .clk       (bitClk),
  .rstN      (rstN),
  .lane0Data (lane0Data),
  .lane0Oe   (lane0Oe),
  .lane1Data (lane1Data),
  .lane1Oe   (lane1Oe),
  .clkOut    (clkOut),
  .clkOe     (clkOe)
);

// File: tb/pixel_frame_serializer_test.sv
`timescale 1ns/1ps
module pixel_frame_serializer_test;

  logic       bitClk = 1'b0;
  logic       rstN = 1'b0;
  logic       txEn = 1'b0;
  logic       twoLaneSel = 1'b0;
  logic [7:0] pixRed = '0, pixGreen = '0, pixBlue = '0;
  logic       pixVsync = 1'b0, pixHsync = 1'b0, pixDe = 1'b0;
  logic       lane0Data, lane0Oe, lane1Data, lane1Oe, clkOut, clkOe;

  int vectors = 0;
  int miscompares = 0;

  // reference model state
  bit        mActive = 0;
  bit        mTwo = 0;
  int        mCnt = 0;
  bit [29:0] mHold = '0;
  bit [29:0] mFrame = '0;

  int lane0Map [15] = '{2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 13, 24, 27, 29};
  int lane1Map [15] = '{0, 1, 14, 15, 16, 17, 18, 19, 20, 21, 22, 23, 25, 26, 28};

  always #2.5 bitClk = ~bitClk;

  pixel_frame_serializer uut (
    .bitClk(bitClk), .rstN(rstN), .txEn(txEn), .twoLaneSel(twoLaneSel),
    .pixRed(pixRed), .pixGreen(pixGreen), .pixBlue(pixBlue),
    .pixVsync(pixVsync), .pixHsync(pixHsync), .pixDe(pixDe),
    .lane0Data(lane0Data), .lane0Oe(lane0Oe), .lane1Data(lane1Data),
    .lane1Oe(lane1Oe), .clkOut(clkOut), .clkOe(clkOe)
  );

  // Frame in sending order per R1, R2 and R11
  function automatic bit [29:0] refFrame();
    bit [29:0] f;
    f[0] = pixBlue[7];
    f[1] = pixBlue[6];
    for (int k = 0; k < 8; k++) begin
      f[2 + k]  = pixRed[7 - k];
      f[10 + k] = pixGreen[7 - k];
    end
    for (int k = 0; k < 6; k++) f[18 + k] = pixBlue[5 - k];
    f[24] = pixVsync;
    f[25] = pixHsync;
    f[26] = pixDe;
    f[27] = 1'b0;
    f[28] = 1'b0;
    f[29] = ^{pixRed, pixGreen, pixBlue, pixVsync, pixHsync, pixDe};
    return f;
  endfunction

  task automatic check1(input string req, input string what, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s at t=%0t: actual %b expected %b", req, what, $time, act, exp);
    end
  endtask

  // One bit clock: advance the model at the edge, compare at the falling edge.
  task automatic step(input string req);
    bit e0, e1, eo1, ec;
    @(posedge bitClk);
    if (!rstN) begin
      mActive = 0; mTwo = 0; mCnt = 0; mHold = '0; mFrame = '0;
    end else if (!mActive || mCnt == (mTwo ? 14 : 29)) begin
      mActive = txEn;
      mTwo    = twoLaneSel;
      mCnt    = 0;
      mFrame  = mHold;
      mHold   = refFrame();
    end else begin
      mCnt++;
    end
    @(negedge bitClk);
    eo1 = mActive && mTwo;
    if (!mActive) begin
      e0 = 0; e1 = 0; ec = 0;
    end else if (mTwo) begin
      e0 = mFrame[lane0Map[mCnt]];
      e1 = mFrame[lane1Map[mCnt]];
      ec = (mCnt < 8);
    end else begin
      e0 = mFrame[mCnt];
      e1 = 0;
      ec = (mCnt < 15);
    end
    check1(req, "lane0Oe", lane0Oe, mActive);
    check1(req, "lane1Oe", lane1Oe, eo1);
    check1(req, "clkOe", clkOe, mActive);
    check1(req, "lane0Data", lane0Data, e0);
    check1(req, "lane1Data", lane1Data, e1);
    check1(req, "clkOut", clkOut, ec);
  endtask

  task automatic setPix(input bit [26:0] v);
    {pixRed, pixGreen, pixBlue, pixVsync, pixHsync, pixDe} = v;
  endtask

  task automatic run(input string req, input int n);
    for (int i = 0; i < n; i++) step(req);
  endtask

  // R10: reset state
  task automatic testReset();
    rstN = 1'b0;
    txEn = 1'b1;
    run("R10", 4);
    rstN = 1'b1;
    txEn = 1'b0;
    run("R5", 3);
  endtask

  // R2, R1, R7: one-lane frames with a new pixel every frame
  task automatic testOneLane();
    bit [26:0] pats [4] = '{27'h5A5A5A5, 27'h1234567, 27'h0F0F0F0, 27'h6DB6DB6};
    twoLaneSel = 1'b0;
    setPix(pats[0]);
    step("R2");
    txEn = 1'b1;
    for (int p = 1; p < 4; p++) begin
      setPix(pats[p]);
      run("R2 R1 R7", 30);
    end
    run("R2 R7", 30);
  endtask

  // R3, R4, R6: two-lane frames
  task automatic testTwoLane();
    bit [26:0] pats [4] = '{27'h2AAAAAA, 27'h7654321, 27'h0000001, 27'h4000000};
    twoLaneSel = 1'b1;
    for (int p = 0; p < 4; p++) begin
      setPix(pats[p]);
      run("R3 R4 R6", 15);
    end
    run("R3 R4 R1", 30);
  endtask

  // R11, R1: all payload ones, then all zeros
  task automatic testReserved();
    setPix('1);
    run("R11 R1", 45);
    twoLaneSel = 1'b0;
    run("R11 R1", 60);
    setPix('0);
    run("R1 R11", 60);
  endtask

  // R8: mode flips mid-frame
  task automatic testModeSwitch();
    setPix(27'h3C3C3C3);
    run("R8", 7);
    twoLaneSel = 1'b1;
    run("R8", 40);
    twoLaneSel = 1'b0;
    run("R8", 50);
  endtask

  // R9: shutdown mid-frame, stay off, restart
  task automatic testShutdown();
    setPix(27'h1F00FF1);
    run("R9", 5);
    txEn = 1'b0;
    run("R9 R5", 40);
    setPix(27'h0A0B0C1);
    run("R5", 3);
    twoLaneSel = 1'b1;
    txEn = 1'b1;
    setPix(27'h7FF0001);
    run("R9 R4", 35);
    txEn = 1'b0;
    run("R9 R5", 20);
  endtask

  initial begin
    #(5ns * 100000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    @(negedge bitClk);
    testReset();
    testOneLane();
    testTwoLane();
    testReserved();
    testModeSwitch();
    testShutdown();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule